// File: doc/BRIEF.md
# Byte String Move, Compare and Fill Engine

This block carries out the string instructions of a processor core on a byte-addressed memory. Software loads three values at the start: a destination pointer, a source pointer (which holds the fill pattern for the fill operation), and an element count. The engine then steps through memory one element at a time over a synchronous single-port memory interface. When it finishes it returns the updated pointers and count, the zero and carry flags produced by a compare, and a modelled execution time that follows a fixed formula for each operation.

There are five operations. Three copy bytes: forward, backward, and copy-until-zero. Compare scans two strings and stops at the first difference or at a terminating zero byte. Fill stores a byte, halfword or word pattern repeatedly.

The controller is a single state machine with eight states:
- `ST_IDLE` waits for `start`.
- `ST_READ` and `ST_WRITE` form the two-cycle copy loop.
- `ST_CMP_A`, `ST_CMP_B` and `ST_CMP_EVAL` form the three-cycle compare loop.
- `ST_FILL` is the one-cycle fill loop.
- `ST_DONE` signals completion.

The transitions are:
- From `ST_IDLE`, `start` goes to `ST_DONE` when the count is zero or the operation code is undefined. Otherwise it goes to `ST_READ` for the copies, `ST_CMP_A` for compare, and `ST_FILL` for fill.
- `ST_READ` always goes to `ST_WRITE`.
- `ST_WRITE` goes back to `ST_READ`, or to `ST_DONE` on its stop condition.
- `ST_CMP_A` goes to `ST_CMP_B`, which goes to `ST_CMP_EVAL`.
- `ST_CMP_EVAL` goes back to `ST_CMP_A`, or to `ST_DONE` on its stop condition.
- `ST_FILL` stays in `ST_FILL` until its last element, then goes to `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `str_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `flag_z`, `flag_c`, `r1_out`, `r2_out` and `r3_out` are all zero.
- R2: Operation code 0 is forward copy. It copies the byte at R2 to R1, increments both pointers, decrements R3, and repeats until R3 is zero.
- R3: Operation code 1 is backward copy. It is the same as forward copy except that both pointers are decremented after each byte.
- R4: Operation code 2 is copy-until-zero. It copies like forward copy and stops after copying a zero byte or when R3 reaches zero.
- R5: Operation code 3 is compare. For each step it reads the byte at R1 and the byte at R2, increments both pointers and decrements R3. It stops when the bytes differ, when the R1 byte is zero, or when R3 reaches zero.
- R6: The flags are set as follows:
  - A compare start sets both flags to 1.
  - Each compare step sets `flag_z` when the two bytes are equal.
  - Each compare step sets `flag_c` when the R1 byte is at least the R2 byte, compared unsigned.
  - No other operation changes the flags.
- R7: Operation code 4 is fill. Each step stores the low bytes of R2 at R1 in little-endian order, advances R1 by the element size and decrements R3 by one. The element size comes from `fill_size`: 0 is a byte, 1 is a halfword, 2 or 3 is a word.
- R8: `cycle_count` is computed from n, the number of elements processed:
  - Compare: 2+4(n/4)+4(n%4).
  - Forward copy and copy-until-zero: 2+3(n/4)+3(n%4).
  - Backward copy: 6+3(n/4)+3(n%4) when n≥4, otherwise 2+3(n%4).
  - Fill: 2+n for words, 2+n/2+n%2 for halfwords, 2+n/4+n%4 for bytes.
  - Any other case gives 2.
- R9: A start with R3 equal to zero, or with an operation code of 5 to 7, raises `done` in the cycle after the start edge. It makes no memory access. Memory is never accessed while `r3_out` is zero.
- R10: `start` is ignored while `busy` is high.
- R11: `done` is a one-cycle pulse. `busy` is high from the start edge up to and including the `done` cycle.
- R12: `mem_req` is low when the engine is idle. Read data returns on `mem_rdata` in the cycle after the read request. Every write decrements `r3_out` by one at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code |
| fill_size | input | 2 | Fill element size |
| r1_in | input | XW | Initial destination pointer |
| r2_in | input | XW | Initial source pointer or fill pattern |
| r3_in | input | XW | Initial element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| r1_out | output | XW | Current destination pointer |
| r2_out | output | XW | Current source pointer or pattern |
| r3_out | output | XW | Remaining count |
| flag_z | output | 1 | Compare equal flag |
| flag_c | output | 1 | Compare no-borrow flag |
| cycle_count | output | XW | Modelled execution cycles |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_size | output | 2 | Write size: 0 byte, 1 halfword, 2 word |
| mem_addr | output | XW | Access address |
| mem_wdata | output | XW | Write data, little-endian |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse inside the busy window.
- A busy run stays busy until it finishes.
- Memory stays quiet when idle and whenever the count is zero.
- A zero-count start completes in the next cycle.
- Every write takes exactly one off the count.
- The flags hold steady while idle.

Only the bench scenarios can show the data behaviour:
- The bytes actually moved, including in overlapping and backward copies.
- The compare stop points and flag values against the bytes compared.
- The fill byte order for each size.
- The per-operation cycle formulas.
- That a start pulse in mid-run leaves the result untouched.

// File: rtl/str_engine_pkg.sv
package str_engine_pkg;

    // Operation codes seen on the op port
    typedef enum logic [2:0] {
        OP_FWD  = 3'd0,
        OP_BWD  = 3'd1,
        OP_CUZ  = 3'd2,
        OP_CMP  = 3'd3,
        OP_FILL = 3'd4
    } str_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_CMP_A,
        ST_CMP_B,
        ST_CMP_EVAL,
        ST_FILL,
        ST_DONE
    } str_state_e;

    // Control strobes from the sequencer to the register file
    typedef struct packed {
        logic load;
        logic step;
        logic latch_a;
        logic cmp_upd;
    } str_ctl_t;

endpackage

// File: rtl/str_fsm.sv
module str_fsm
    import str_engine_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op_in,
    input  logic       cnt_in_zero,
    input  logic [2:0] op_q,
    input  logic       cnt_last,
    input  logic [7:0] rdata,
    input  logic [7:0] byte_a,
    output str_ctl_t   ctl,
    output logic       mem_req,
    output logic       mem_we,
    output logic       addr_src,
    output logic       fill_wr,
    output logic       busy,
    output logic       done
);

    str_state_e state, state_nx;

    logic copy_stop;
    logic cmp_stop;

    // R4: copy-until-zero ends after the zero byte is written
    assign copy_stop = cnt_last || ((op_q == OP_CUZ) && (rdata == 8'd0));
    // R5: mismatch, terminator, or exhausted count
    assign cmp_stop  = cnt_last || (byte_a != rdata) || (byte_a == 8'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (cnt_in_zero) begin
                        state_nx = ST_DONE;   // R9
                    end else begin
                        case (op_in)
                            OP_FWD, OP_BWD, OP_CUZ: state_nx = ST_READ;
                            OP_CMP:                 state_nx = ST_CMP_A;
                            OP_FILL:                state_nx = ST_FILL;
                            default:                state_nx = ST_DONE;
                        endcase
                    end
                end
            end
            ST_READ:     state_nx = ST_WRITE;
            ST_WRITE:    state_nx = copy_stop ? ST_DONE : ST_READ;
            ST_CMP_A:    state_nx = ST_CMP_B;
            ST_CMP_B:    state_nx = ST_CMP_EVAL;
            ST_CMP_EVAL: state_nx = cmp_stop ? ST_DONE : ST_CMP_A;
            ST_FILL:     state_nx = cnt_last ? ST_DONE : ST_FILL;
            ST_DONE:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl      = '0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        addr_src = 1'b0;
        fill_wr  = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                ctl.load = start;     // R10: loads only from idle
            end
            ST_READ: begin
                mem_req  = 1'b1;
                addr_src = 1'b1;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                ctl.step = 1'b1;
            end
            ST_CMP_A: begin
                mem_req  = 1'b1;
            end
            ST_CMP_B: begin
                mem_req     = 1'b1;
                addr_src    = 1'b1;
                ctl.latch_a = 1'b1;
            end
            ST_CMP_EVAL: begin
                ctl.step    = 1'b1;
                ctl.cmp_upd = 1'b1;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                fill_wr  = 1'b1;
                ctl.step = 1'b1;
            end
            ST_DONE: begin
                done     = 1'b1;      // R11
            end
        endcase
    end

endmodule

// File: rtl/str_regs.sv
module str_regs
    import str_engine_pkg::*;
#(
    parameter int XW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  str_ctl_t      ctl,
    input  logic [2:0]    op_in,
    input  logic [1:0]    size_in,
    input  logic [XW-1:0] r1_in,
    input  logic [XW-1:0] r2_in,
    input  logic [XW-1:0] r3_in,
    input  logic [7:0]    rdata,
    output logic [XW-1:0] r1_q,
    output logic [XW-1:0] r2_q,
    output logic [XW-1:0] r3_q,
    output logic [XW-1:0] n_q,
    output logic [2:0]    op_q,
    output logic [1:0]    size_q,
    output logic [7:0]    byte_a,
    output logic          flag_z,
    output logic          flag_c
);

    logic [XW-1:0] fill_step;

    // R7: element size in bytes
    always_comb begin
        case (size_q)
            2'd0:    fill_step = XW'(1);
            2'd1:    fill_step = XW'(2);
            default: fill_step = XW'(4);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r1_q   <= '0;
            r2_q   <= '0;
            r3_q   <= '0;
            n_q    <= '0;
            op_q   <= '0;
            size_q <= '0;
            byte_a <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else begin
            if (ctl.load) begin
                r1_q   <= r1_in;
                r2_q   <= r2_in;
                r3_q   <= r3_in;
                n_q    <= '0;
                op_q   <= op_in;
                size_q <= size_in;
                if (op_in == OP_CMP) begin
                    flag_z <= 1'b1;   // R6
                    flag_c <= 1'b1;
                end
            end
            if (ctl.step) begin
                r3_q <= r3_q - XW'(1);
                n_q  <= n_q + XW'(1);
                case (op_q)
                    OP_BWD: begin
                        r1_q <= r1_q - XW'(1);   // R3
                        r2_q <= r2_q - XW'(1);
                    end
                    OP_FILL: begin
                        r1_q <= r1_q + fill_step;
                    end
                    default: begin
                        r1_q <= r1_q + XW'(1);
                        r2_q <= r2_q + XW'(1);
                    end
                endcase
            end
            if (ctl.latch_a) begin
                byte_a <= rdata;
            end
            if (ctl.cmp_upd) begin
                flag_z <= (byte_a == rdata);
                flag_c <= (byte_a >= rdata);
            end
        end
    end

endmodule

// File: rtl/str_cost.sv
module str_cost
    import str_engine_pkg::*;
#(
    parameter int XW = 32
) (
    input  logic [2:0]    op,
    input  logic [1:0]    size,
    input  logic [XW-1:0] n,
    output logic [XW-1:0] cycles
);

    logic [XW-1:0] quarter, rem, half, odd, grp;

    assign quarter = n >> 2;
    assign rem     = {{(XW-2){1'b0}}, n[1:0]};
    assign half    = n >> 1;
    assign odd     = {{(XW-1){1'b0}}, n[0]};
    assign grp     = quarter + rem;

    // R8: per-operation timing formula
    always_comb begin
        case (op)
            OP_CMP:         cycles = XW'(2) + (grp << 2);
            OP_FWD, OP_CUZ: cycles = XW'(2) + grp * XW'(3);
            OP_BWD:         cycles = (n >= XW'(4)) ? (XW'(6) + grp * XW'(3))
                                                   : (XW'(2) + rem * XW'(3));
            OP_FILL: begin
                case (size)
                    2'd0:    cycles = XW'(2) + quarter + rem;
                    2'd1:    cycles = XW'(2) + half + odd;
                    default: cycles = XW'(2) + n;
                endcase
            end
            default:        cycles = XW'(2);
        endcase
    end

endmodule

// File: rtl/str_engine.sv
module str_engine
    import str_engine_pkg::*;
#(
    parameter int XW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [1:0]    fill_size,
    input  logic [XW-1:0] r1_in,
    input  logic [XW-1:0] r2_in,
    input  logic [XW-1:0] r3_in,
    output logic          busy,
    output logic          done,
    output logic [XW-1:0] r1_out,
    output logic [XW-1:0] r2_out,
    output logic [XW-1:0] r3_out,
    output logic          flag_z,
    output logic          flag_c,
    output logic [XW-1:0] cycle_count,
    output logic          mem_req,
    output logic          mem_we,
    output logic [1:0]    mem_size,
    output logic [XW-1:0] mem_addr,
    output logic [XW-1:0] mem_wdata,
    input  logic [7:0]    mem_rdata
);

    str_ctl_t      ctl;
    logic [XW-1:0] n_q;
    logic [2:0]    op_q;
    logic [1:0]    size_q;
    logic [7:0]    byte_a;
    logic          addr_src;
    logic          fill_wr;

    str_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_in      (op),
        .cnt_in_zero(r3_in == '0),
        .op_q       (op_q),
        .cnt_last   (r3_out == XW'(1)),
        .rdata      (mem_rdata),
        .byte_a     (byte_a),
        .ctl        (ctl),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .addr_src   (addr_src),
        .fill_wr    (fill_wr),
        .busy       (busy),
        .done       (done)
    );

    str_regs #(.XW(XW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (ctl),
        .op_in  (op),
        .size_in(fill_size),
        .r1_in  (r1_in),
        .r2_in  (r2_in),
        .r3_in  (r3_in),
        .rdata  (mem_rdata),
        .r1_q   (r1_out),
        .r2_q   (r2_out),
        .r3_q   (r3_out),
        .n_q    (n_q),
        .op_q   (op_q),
        .size_q (size_q),
        .byte_a (byte_a),
        .flag_z (flag_z),
        .flag_c (flag_c)
    );

    str_cost #(.XW(XW)) u_cost (
        .op    (op_q),
        .size  (size_q),
        .n     (n_q),
        .cycles(cycle_count)
    );

    // Memory port steering
    assign mem_addr  = addr_src ? r2_out : r1_out;
    assign mem_size  = fill_wr ? size_q : 2'd0;
    assign mem_wdata = fill_wr ? r2_out : {{(XW-8){1'b0}}, mem_rdata};

endmodule

// File: rtl/str_engine_chk.sv
module str_engine_chk #(
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [XW-1:0] r3_in,
    input logic          busy,
    input logic          done,
    input logic [XW-1:0] r3_out,
    input logic          flag_z,
    input logic          flag_c,
    input logic          mem_req,
    input logic          mem_we
);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && r3_in == '0) |=> done);

    a_r9_no_access_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r3_out == '0) |-> !mem_req);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r12_write_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (r3_out == $past(r3_out) - XW'(1)));

    a_r6_flags_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(flag_z) && $stable(flag_c)));

endmodule

bind str_engine str_engine_chk #(.XW(XW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .r3_in  (r3_in),
    .busy   (busy),
    .done   (done),
    .r3_out (r3_out),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .mem_req(mem_req),
    .mem_we (mem_we)
);

// File: tb/tb_str_engine.sv
`timescale 1ns/1ps
module tb_str_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] r1_i = '0, r2_i = '0, r3_i = '0;
    logic        busy, done, flag_z, flag_c, mem_req, mem_we;
    logic [31:0] r1_out, r2_out, r3_out, cycle_count, mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    logic        preload = 1'b0;
    int          acc_cnt = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    logic        ez = 1'b0, ec = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    str_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .fill_size(size_i),
        .r1_in(r1_i), .r2_in(r2_i), .r3_in(r3_i), .busy(busy), .done(done),
        .r1_out(r1_out), .r2_out(r2_out), .r3_out(r3_out), .flag_z(flag_z),
        .flag_c(flag_c), .cycle_count(cycle_count), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int wbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // Synchronous memory: read byte returns one cycle after the request
    always @(posedge clk) begin
        if (preload) begin
            mem <= ref_mem;
        end else if (mem_req) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (k < wbytes(mem_size))
                        mem[mem_addr[7:0] + 8'(k)] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fcyc(input int op, input int sz, input int n);
        case (op)
            3: return 32'(2 + 4 * (n / 4) + 4 * (n % 4));
            0, 2: return 32'(2 + 3 * (n / 4) + 3 * (n % 4));
            1: return (n >= 4) ? 32'(6 + 3 * (n / 4) + 3 * (n % 4)) : 32'(2 + 3 * (n % 4));
            4: begin
                if (sz == 0) return 32'(2 + n / 4 + n % 4);
                if (sz == 1) return 32'(2 + n / 2 + n % 2);
                return 32'(2 + n);
            end
            default: return 32'd2;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Reference model from the requirements; mutates ref_mem
    task automatic ref_run(input int op, input int sz, input logic [31:0] a1,
                           input logic [31:0] a2, input logic [31:0] a3,
                           output logic [31:0] e1, output logic [31:0] e2,
                           output logic [31:0] e3, output logic [31:0] ecyc);
        logic [7:0] a, b;
        int n = 0;
        int nb;
        e1 = a1; e2 = a2; e3 = a3;
        if (op == 3) begin ez = 1'b1; ec = 1'b1; end
        case (op)
            0, 1, 2: begin
                while (e3 != 0) begin
                    b = ref_mem[e2[7:0]];
                    ref_mem[e1[7:0]] = b;
                    if (op == 1) begin e1--; e2--; end else begin e1++; e2++; end
                    e3--; n++;
                    if (op == 2 && b == 8'd0) break;
                end
            end
            3: begin
                while (e3 != 0) begin
                    a = ref_mem[e1[7:0]];
                    b = ref_mem[e2[7:0]];
                    e1++; e2++; e3--; n++;
                    ez = (a == b);
                    ec = (a >= b);
                    if (a != b || a == 8'd0) break;
                end
            end
            4: begin
                nb = wbytes(2'(sz));
                while (e3 != 0) begin
                    for (int k = 0; k < nb; k++) ref_mem[e1[7:0] + 8'(k)] = a2[8*k +: 8];
                    e1 = e1 + 32'(nb);
                    e3--; n++;
                end
            end
            default: ;
        endcase
        ecyc = fcyc(op, sz, n);
    endtask

    task automatic rand_mem(input bit nonzero);
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = 8'($urandom);
            if (nonzero && ref_mem[i] == 8'd0) ref_mem[i] = 8'h5a;
        end
    endtask

    task automatic commit();
        @(negedge clk); preload = 1'b1;
        @(negedge clk); preload = 1'b0;
    endtask

    task automatic run_op(input int op, input int sz, input logic [31:0] a1,
                          input logic [31:0] a2, input logic [31:0] a3, input bit poke);
        logic [31:0] e1, e2, e3, ecyc;
        int lat, acc0, diffs;
        string tag;
        ref_run(op, sz, a1, a2, a3, e1, e2, e3, ecyc);
        tag = tag_of(op);
        @(negedge clk);
        op_i = 3'(op); size_i = 2'(sz); r1_i = a1; r2_i = a2; r3_i = a3;
        start = 1'b1; acc0 = acc_cnt;
        @(negedge clk);
        start = 1'b0; lat = 1;
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 3) begin
                // R10: a start in mid-run must be ignored
                start = 1'b1; op_i = 3'd4; r3_i = 32'd3; r1_i = 32'd10; r2_i = 32'hffff_ffff;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(tag, 32'(done), 32'd1, "done seen");
        check(tag, r1_out, e1, "r1");
        check(tag, r2_out, e2, "r2");
        check(tag, r3_out, e3, "r3");
        check("R6", {30'd0, flag_z, flag_c}, {30'd0, ez, ec}, "flags z,c");
        check("R8", cycle_count, ecyc, "cycle count");
        diffs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diffs++;
        check(poke ? "R10" : tag, 32'(diffs), 32'd0, "memory mismatches");
        if (a3 == 0 || op > 4) begin
            check("R9", 32'(lat), 32'd1, "done latency");
            check("R9", 32'(acc_cnt - acc0), 32'd0, "memory accesses");
        end
        @(negedge clk);
        check("R11", {30'd0, done, busy}, 32'd0, "done/busy after pulse");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {28'd0, busy, done, flag_z, flag_c}, 32'd0, "busy/done/flags");
        check("R1", r1_out | r2_out | r3_out, 32'd0, "pointers and count");
        check("R1", 32'(mem_req), 32'd0, "mem_req");
        rst_n = 1'b1;
        @(negedge clk);

        // Directed copies (R2, R3) including the backward boundary n=4
        rand_mem(0); commit(); run_op(0, 0, 32'd20, 32'd100, 32'd5, 0);
        rand_mem(0); commit(); run_op(1, 0, 32'd60, 32'd150, 32'd5, 0);
        rand_mem(0); commit(); run_op(1, 0, 32'd60, 32'd150, 32'd4, 0);
        rand_mem(0); commit(); run_op(0, 0, 32'd41, 32'd40, 32'd6, 0);  // overlap
        // R4: zero at index 2, then no zero within count
        rand_mem(1); ref_mem[102] = 8'd0; commit(); run_op(2, 0, 32'd20, 32'd100, 32'd9, 0);
        rand_mem(1); commit(); run_op(2, 0, 32'd20, 32'd100, 32'd3, 0);
        // R5/R6: equal strings, a<b mismatch, a>b mismatch, shared terminator
        rand_mem(1);
        for (int i = 0; i < 6; i++) ref_mem[120 + i] = ref_mem[30 + i];
        commit(); run_op(3, 0, 32'd30, 32'd120, 32'd6, 0);
        rand_mem(1);
        for (int i = 0; i < 6; i++) ref_mem[120 + i] = ref_mem[30 + i];
        ref_mem[33] = 8'h10; ref_mem[123] = 8'h20;
        commit(); run_op(3, 0, 32'd30, 32'd120, 32'd6, 0);
        rand_mem(1);
        for (int i = 0; i < 6; i++) ref_mem[120 + i] = ref_mem[30 + i];
        ref_mem[31] = 8'hf0; ref_mem[121] = 8'h01;
        commit(); run_op(3, 0, 32'd30, 32'd120, 32'd6, 0);
        rand_mem(1);
        for (int i = 0; i < 6; i++) ref_mem[120 + i] = ref_mem[30 + i];
        ref_mem[32] = 8'd0; ref_mem[122] = 8'd0;
        commit(); run_op(3, 0, 32'd30, 32'd120, 32'd6, 0);
        // R7: every fill size
        for (int s = 0; s < 4; s++) begin
            rand_mem(0); commit(); run_op(4, s, 32'd50, 32'h8badf00d, 32'd5, 0);
        end
        // R9: zero count for each op, and undefined codes
        for (int o = 0; o < 5; o++) begin
            rand_mem(0); commit(); run_op(o, 2, 32'd20, 32'd100, 32'd0, 0);
        end
        rand_mem(0); commit(); run_op(6, 0, 32'd20, 32'd100, 32'd4, 0);
        // R10: start pulse during a run
        rand_mem(0); commit(); run_op(0, 0, 32'd20, 32'd100, 32'd8, 1);

        // Constrained random mix
        for (int it = 0; it < 40; it++) begin
            int o, s, n;
            logic [31:0] p1, p2;
            o  = int'($urandom % 6);
            s  = int'($urandom % 4);
            n  = int'($urandom % 13);
            p1 = 32'(20 + $urandom % 80);
            p2 = 32'(120 + $urandom % 80);
            rand_mem(o == 2 || o == 3);
            if (o == 2 && ($urandom % 2) == 1) ref_mem[p2[7:0] + 8'($urandom % 8)] = 8'd0;
            if (o == 3) begin
                for (int i = 0; i < n; i++) ref_mem[p2[7:0] + 8'(i)] = ref_mem[p1[7:0] + 8'(i)];
                if (n > 0 && ($urandom % 2) == 1) ref_mem[p2[7:0] + 8'($urandom % n)] = 8'($urandom);
                if (n > 0 && ($urandom % 3) == 0) begin
                    int j;
                    j = int'($urandom % n);
                    ref_mem[p1[7:0] + 8'(j)] = 8'd0;
                    ref_mem[p2[7:0] + 8'(j)] = 8'd0;
                end
            end
            if (o == 5) o = 7;
            if (o == 4) p2 = $urandom;
            commit();
            run_op(o, s, p1, p2, 32'(n), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule